// File: doc/BRIEF.md
# Frame-Synchronous Register Write Sequencer

This block holds register writes that a host wants applied at a precise point in an image sensor's frame sequence. The host tags each write with a frame distance of 0 to 14 relative to the frame now running. The block parks the write in one of sixteen frame slots and keeps it there until the target frame begins. One instance sits beside each sensor channel and follows that channel's frame-start pulses. When the frame for a slot opens, the slot's writes leave one at a time toward the downstream bus master.

That downstream path is modelled only as a request/acknowledge pair. The block presents a 16-bit register address and a 16-bit data word, and holds them until the consumer acknowledges. Each slot is a first-in first-out queue of eight entries. A ninth entry for a full slot is discarded and raises a sticky error. Sometimes a frame opens before the previous slot has emptied. The block then completes the older slot first, and a saturating counter records each such overrun.

Top module: `frame_write_sequencer`

## Requirements
- R1: After synchronous reset, wr_req is low, frame_num is 0, late_count is 0 and overflow_err is 0.
- R2: Each cycle with frame_start high advances frame_num by one, modulo 16 (15 wraps to 0).
- R3: A host write with host_offset 0 is presented on wr_req/wr_addr/wr_data during the current frame, without waiting for another frame_start.
- R4: A host write with host_offset k (1 to 14) is presented only after the k-th following frame_start, and not before it.
- R5: Writes that target the same frame are presented in the order the host pushed them.
- R6: A frame slot holds 8 entries. A further write to a full slot is dropped and sets overflow_err, which stays set until reset.
- R7: A host write with host_offset 15 is ignored: it is never presented and occupies no slot.
- R8: Once wr_req rises, wr_addr and wr_data stay stable and wr_req stays high until the cycle wr_ack is high. Each acknowledge retires exactly one write.
- R9: A frame_start that arrives while the slot being drained still holds entries, or while draining is behind the frame counter, increments late_count (saturating). The older slot is still emptied completely before the newer one.
- R10: Reset discards every queued write and returns the frame counter to 0, so nothing queued before reset is presented afterwards.
- R11: Slot selection wraps modulo 16: a write with offset 14 pushed at frame 5 is presented after the 14th following frame_start, when frame_num reads 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse at the start of each sensor frame |
| host_valid | input | 1 | Host pushes one write this cycle |
| host_offset | input | 4 | Target frame distance from the current frame (0..14; 15 ignored) |
| host_addr | input | 16 | Register address of the pushed write |
| host_data | input | 16 | Register data of the pushed write |
| wr_req | output | 1 | A write is presented to the bus master |
| wr_addr | output | 16 | Address of the presented write |
| wr_data | output | 16 | Data of the presented write |
| wr_ack | input | 1 | Bus master accepts the presented write |
| frame_num | output | 4 | Current frame counter |
| late_count | output | 8 | Saturating count of frame starts that found draining incomplete |
| overflow_err | output | 1 | Sticky flag: a write to a full slot was dropped |

## Verification
The assertions assume that wr_ack is only raised while wr_req is high. They also assume that frame_start is a single-cycle pulse and never lands two frames ahead of the draining engine, since a lag of two frames would let a 14-ahead write land in the slot being emptied. The stimulus spaces frame pulses far enough apart for each slot to empty, except in the one deliberate overrun case, and even there the lag stays at a single frame. Host pushes are never issued in the same cycle as frame_start, and acknowledges come only in response to a visible request.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_entry_t;

    localparam int ENTRY_W = $bits(wr_entry_t);

    typedef enum logic {
        DR_IDLE = 1'b0,
        DR_BUSY = 1'b1
    } drain_state_t;
endpackage

// File: rtl/fsq_frame_ctr.sv
module fsq_frame_ctr #(
    parameter int FRAME_W   = 4,
    parameter int MAX_AHEAD = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic               host_valid,
    input  logic [FRAME_W-1:0] host_offset,
    output logic [FRAME_W-1:0] cur_frame,
    output logic               push_ok,
    output logic [FRAME_W-1:0] push_slot
);
    localparam logic [FRAME_W-1:0] AHEAD_LIM = FRAME_W'(MAX_AHEAD);

    always_ff @(posedge clk) begin
        if (rst) cur_frame <= '0;
        else if (frame_start) cur_frame <= cur_frame + 1'b1;
    end

    // relative distance folded onto the ring of slots
    always_comb begin
        push_ok   = host_valid && (host_offset <= AHEAD_LIM);
        push_slot = cur_frame + host_offset;
    end

    assert_frame_step_R2: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (cur_frame == $past(cur_frame) + 1'b1));
endmodule

// File: rtl/fsq_slot_store.sv
module fsq_slot_store
    import fsq_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int DEPTH     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push_en,
    input  logic [$clog2(NUM_SLOTS)-1:0] push_slot,
    input  wr_entry_t                    push_entry,
    input  logic                         pop_en,
    input  logic [$clog2(NUM_SLOTS)-1:0] pop_slot,
    output wr_entry_t                    head_entry,
    output logic [$clog2(DEPTH):0]       rd_fill,
    output logic                         overflow
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int FILL_W = PTR_W + 1;
    localparam int MEM_N  = NUM_SLOTS * DEPTH;
    localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

    logic [ENTRY_W-1:0] mem [MEM_N];
    logic [PTR_W-1:0]   wptr [NUM_SLOTS];
    logic [PTR_W-1:0]   rptr [NUM_SLOTS];
    logic [FILL_W-1:0]  fill [NUM_SLOTS];
    logic               push_hit [NUM_SLOTS];
    logic               pop_hit  [NUM_SLOTS];
    logic               push_accept;

    assign push_accept = push_en && (fill[push_slot] != FULL);
    assign overflow    = push_en && !push_accept;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign push_hit[g] = push_accept && (push_slot == SLOT_W'(g));
        assign pop_hit[g]  = pop_en && (pop_slot == SLOT_W'(g));

        assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
            (push_en && push_slot == SLOT_W'(g) && fill[g] == FULL && !pop_hit[g])
            |=> (fill[g] == FULL));
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (rst) begin
                wptr[s] <= '0;
                rptr[s] <= '0;
                fill[s] <= '0;
            end else begin
                if (push_hit[s]) wptr[s] <= wptr[s] + 1'b1;
                if (pop_hit[s])  rptr[s] <= rptr[s] + 1'b1;
                case ({push_hit[s], pop_hit[s]})
                    2'b10:   fill[s] <= fill[s] + 1'b1;
                    2'b01:   fill[s] <= fill[s] - 1'b1;
                    default: fill[s] <= fill[s];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_accept) mem[{push_slot, wptr[push_slot]}] <= push_entry;
    end

    assign head_entry = wr_entry_t'(mem[{pop_slot, rptr[pop_slot]}]);
    assign rd_fill    = fill[pop_slot];
endmodule

// File: rtl/fsq_drain.sv
module fsq_drain
    import fsq_pkg::*;
#(
    parameter int SLOT_W = 4,
    parameter int FILL_W = 4,
    parameter int LATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [SLOT_W-1:0] cur_frame,
    input  logic [FILL_W-1:0] rd_fill,
    input  wr_entry_t         head_entry,
    output logic [SLOT_W-1:0] eng_slot,
    output logic              pop_en,
    output logic              wr_req,
    output wr_entry_t         wr_out,
    input  logic              wr_ack,
    output logic [LATE_W-1:0] late_count
);
    drain_state_t state;
    logic         behind;

    assign behind = (eng_slot != cur_frame) || (rd_fill != '0);
    assign pop_en = (state == DR_IDLE) && (rd_fill != '0);
    assign wr_req = (state == DR_BUSY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= DR_IDLE;
            eng_slot <= '0;
            wr_out   <= '0;
        end else begin
            case (state)
                DR_IDLE: begin
                    if (rd_fill != '0) begin
                        wr_out <= head_entry;
                        state  <= DR_BUSY;
                    end else if (eng_slot != cur_frame) begin
                        eng_slot <= eng_slot + 1'b1;
                    end
                end
                DR_BUSY: if (wr_ack) state <= DR_IDLE;
                default: state <= DR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) late_count <= '0;
        else if (frame_start && behind && (late_count != {LATE_W{1'b1}}))
            late_count <= late_count + 1'b1;
    end

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_out)));

    assert_release_on_ack_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_req) |-> $past(wr_ack));

    assert_late_monotonic_R9: assert property (@(posedge clk) disable iff (rst)
        (late_count != '0) |=> (late_count != '0));
endmodule

// File: rtl/frame_write_sequencer.sv
module frame_write_sequencer
    import fsq_pkg::*;
#(
    parameter int FRAME_W    = 4,
    parameter int MAX_AHEAD  = 14,
    parameter int SLOT_DEPTH = 8,
    parameter int LATE_W     = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic               host_valid,
    input  logic [FRAME_W-1:0] host_offset,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]  host_data,
    output logic               wr_req,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    input  logic               wr_ack,
    output logic [FRAME_W-1:0] frame_num,
    output logic [LATE_W-1:0]  late_count,
    output logic               overflow_err
);
    localparam int NUM_SLOTS = 1 << FRAME_W;
    localparam int FILL_W    = $clog2(SLOT_DEPTH) + 1;

    logic               push_ok;
    logic [FRAME_W-1:0] push_slot;
    logic [FRAME_W-1:0] eng_slot;
    logic               pop_en;
    logic [FILL_W-1:0]  rd_fill;
    logic               overflow;
    wr_entry_t          push_entry;
    wr_entry_t          head_entry;
    wr_entry_t          wr_out;

    assign push_entry = '{addr: host_addr, data: host_data};

    fsq_frame_ctr #(.FRAME_W(FRAME_W), .MAX_AHEAD(MAX_AHEAD)) u_ctr (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .host_valid(host_valid), .host_offset(host_offset),
        .cur_frame(frame_num), .push_ok(push_ok), .push_slot(push_slot)
    );

    fsq_slot_store #(.NUM_SLOTS(NUM_SLOTS), .DEPTH(SLOT_DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .push_en(push_ok), .push_slot(push_slot), .push_entry(push_entry),
        .pop_en(pop_en), .pop_slot(eng_slot),
        .head_entry(head_entry), .rd_fill(rd_fill), .overflow(overflow)
    );

    fsq_drain #(.SLOT_W(FRAME_W), .FILL_W(FILL_W), .LATE_W(LATE_W)) u_drain (
        .clk(clk), .rst(rst), .frame_start(frame_start), .cur_frame(frame_num),
        .rd_fill(rd_fill), .head_entry(head_entry), .eng_slot(eng_slot),
        .pop_en(pop_en), .wr_req(wr_req), .wr_out(wr_out), .wr_ack(wr_ack),
        .late_count(late_count)
    );

    assign wr_addr = wr_out.addr;
    assign wr_data = wr_out.data;

    always_ff @(posedge clk) begin
        if (rst) overflow_err <= 1'b0;
        else if (overflow) overflow_err <= 1'b1;
    end

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        overflow_err |=> overflow_err);

    assert_offset15_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (host_valid && host_offset == {FRAME_W{1'b1}}) |-> !push_ok);
endmodule

// File: tb/frame_write_sequencer_tb.sv
module frame_write_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        frame_start;
    logic        host_valid;
    logic [3:0]  host_offset;
    logic [15:0] host_addr;
    logic [15:0] host_data;
    logic        wr_req;
    logic [15:0] wr_addr;
    logic [15:0] wr_data;
    logic        wr_ack;
    logic [3:0]  frame_num;
    logic [7:0]  late_count;
    logic        overflow_err;

    always #10 clk = ~clk;

    frame_write_sequencer u_dut (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .host_valid(host_valid), .host_offset(host_offset),
        .host_addr(host_addr), .host_data(host_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .frame_num(frame_num), .late_count(late_count), .overflow_err(overflow_err)
    );

    // {offset, addr, data}
    localparam logic [35:0] VEC [0:9] = '{
        36'h2_1001_A001, 36'h0_1002_A002, 36'h5_1003_A003, 36'h2_1004_A004,
        36'hE_1005_A005, 36'hF_1006_A006, 36'h1_1007_A007, 36'h2_1008_A008,
        36'h0_1009_A009, 36'h9_100A_A00A
    };

    int checks = 0;
    int fails  = 0;
    logic [31:0] log_q [0:127];
    int log_n = 0;
    int stall = 0;
    int hold_cnt = 0;
    int last_hold = 0;
    int stable_bad = 0;
    logic [31:0] held;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic push(input logic [3:0] off, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        host_valid = 1'b1; host_offset = off; host_addr = a; host_data = d;
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    task automatic pulse_frame(input int gap);
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // consumer model: optional stall, then acknowledge and log
    initial begin
        wr_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (wr_ack) wr_ack = 1'b0;
            else if (wr_req) begin
                if (hold_cnt == 0) held = {wr_addr, wr_data};
                else if ({wr_addr, wr_data} != held) stable_bad++;
                if (hold_cnt >= stall) begin
                    log_q[log_n] = {wr_addr, wr_data};
                    log_n++;
                    last_hold = hold_cnt;
                    hold_cnt = 0;
                    wr_ack = 1'b1;
                end else hold_cnt++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int base;
        int got;
        int m;
        rst = 1'b1; frame_start = 1'b0; host_valid = 1'b0;
        host_offset = '0; host_addr = '0; host_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 wr_req", {31'b0, wr_req}, 32'd0);
        chk("R1 frame_num", {28'b0, frame_num}, 32'd0);
        chk("R1 late_count", {24'b0, late_count}, 32'd0);
        chk("R1 overflow_err", {31'b0, overflow_err}, 32'd0);

        // table walk: push all at frame 0, then check each frame's release
        for (int j = 0; j < 10; j++) push(VEC[j][35:32], VEC[j][31:16], VEC[j][15:0]);
        repeat (30) @(negedge clk);
        base = 0;
        for (int k = 0; k < 16; k++) begin
            if (k > 0) pulse_frame(40);
            got = log_n - base;
            m = 0;
            for (int j = 0; j < 10; j++) begin
                if (VEC[j][35:32] == 4'(k) && k != 15) begin
                    // R3 (k=0), R4 (k>0), R5 same-frame order
                    if (m < got) chk(k == 0 ? "R3 immediate entry" : "R4/R5 frame entry",
                                     log_q[base + m], VEC[j][31:0]);
                    m++;
                end
            end
            chk(k == 15 ? "R7 offset 15 ignored count" : "R4 entries per frame",
                got, m);
            base = log_n;
        end
        chk("R2 frame_num after 15", {28'b0, frame_num}, 32'd15);
        pulse_frame(5);
        chk("R2 frame_num wrap", {28'b0, frame_num}, 32'd0);

        // R11 wrap of slot index
        for (int i = 0; i < 5; i++) pulse_frame(5);
        push(4'd14, 16'h2000, 16'hB000);
        base = log_n;
        for (int i = 0; i < 13; i++) pulse_frame(10);
        chk("R11 not before 14th frame", log_n - base, 32'd0);
        pulse_frame(20);
        chk("R11 frame_num", {28'b0, frame_num}, 32'd3);
        chk("R11 released count", log_n - base, 32'd1);
        chk("R11 released entry", log_q[base], 32'h2000_B000);

        // R6 overflow and R5 order on a full slot
        base = log_n;
        for (int i = 0; i < 9; i++) push(4'd1, 16'h3000 + 16'(i), 16'hC000 + 16'(i));
        chk("R6 overflow_err set", {31'b0, overflow_err}, 32'd1);
        pulse_frame(60);
        chk("R6 eight released", log_n - base, 32'd8);
        for (int i = 0; i < 8; i++)
            chk("R5 fifo order", log_q[base + i], {16'h3000 + 16'(i), 16'hC000 + 16'(i)});
        chk("R6 sticky", {31'b0, overflow_err}, 32'd1);

        // R8 stall: request held stable
        stall = 6; stable_bad = 0;
        base = log_n;
        push(4'd0, 16'h4000, 16'hD000);
        repeat (25) @(negedge clk);
        chk("R8 one entry per ack", log_n - base, 32'd1);
        chk("R8 held cycles", last_hold, 32'd6);
        chk("R8 stable while stalled", stable_bad, 32'd0);
        chk("R8 entry", log_q[base], 32'h4000_D000);

        // R9 late frame
        stall = 20;
        base = log_n;
        chk("R9 late before", {24'b0, late_count}, 32'd0);
        push(4'd1, 16'h5001, 16'hE001);
        push(4'd1, 16'h5002, 16'hE002);
        push(4'd2, 16'h5003, 16'hE003);
        pulse_frame(4);
        pulse_frame(100);
        chk("R9 late counted", {24'b0, late_count}, 32'd1);
        chk("R9 drained all", log_n - base, 32'd3);
        chk("R9 order a", log_q[base], 32'h5001_E001);
        chk("R9 order b", log_q[base + 1], 32'h5002_E002);
        chk("R9 order c", log_q[base + 2], 32'h5003_E003);
        stall = 0;

        // R10 reset clears queued writes
        push(4'd2, 16'h6001, 16'hF001);
        push(4'd3, 16'h6002, 16'hF002);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 frame_num after reset", {28'b0, frame_num}, 32'd0);
        chk("R1 late after reset", {24'b0, late_count}, 32'd0);
        chk("R1 err after reset", {31'b0, overflow_err}, 32'd0);
        chk("R1 wr_req after reset", {31'b0, wr_req}, 32'd0);
        base = log_n;
        for (int i = 0; i < 4; i++) pulse_frame(15);
        chk("R10 nothing released", log_n - base, 32'd0);
        chk("R10 counter restarted", {28'b0, frame_num}, 32'd4);

        finish_run();
    end
endmodule